// File: doc/BRIEF.md
# Spacecraft Time Register Unit

This block keeps mission time. The time has two parts: a 32-bit count of whole seconds and a 16-bit sub-second field. A fast reference clock is divided down to a tick at 256 ticks per second. Each tick raises a one-cycle interrupt strobe and advances the sub-second field. An external one-second pulse marks the start of each second, and the tick phase is locked to that pulse.

Time arrives in two steps. A time message can be delivered at any point between two pulses. It carries the second that was just marked. The block adds one to that value and holds the result in a staging register. On the next pulse, the staged value becomes the live seconds count. If no message arrived in the previous second, the pulse advances the seconds count by one instead. Software stamps packets from a snapshot register. A single request fills that register with all 48 bits in one cycle, so the result is never torn across a tick.

Top module: `mission_time_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the live seconds, the sub-second field, the snapshot outputs and the staged-data flag all clear to zero, and `tick_irq_o` is low after the edge.
- R2: With no pulse, `tick_irq_o` is high for exactly one cycle in every `REF_DIV` cycles (default 32768, which gives 256 Hz from a 2^23 Hz reference).
- R3: A pulse restarts the divider. `tick_irq_o` is low in the pulse cycle, and the first following tick appears `REF_DIV` cycles after the pulse cycle.
- R4: The tick count sits in the upper `$clog2(TICKS_PER_SEC)` bits of `live_sub_o` (bits 15:8 by default), and the lower bits are always zero. Each tick without a pulse adds one to the count. The count wraps to zero after its largest value.
- R5: A pulse clears `live_sub_o` to zero on the edge where it is sampled.
- R6: A message with value V, sampled with `upd_valid_i` high, stages V+1. The next pulse loads V+1 into `live_sec_o`.
- R7: A pulse with no staged value adds one to `live_sec_o`.
- R8: A staged value is used by one pulse only. A second pulse with no new message adds one to the loaded value.
- R9: A message that arrives in the same cycle as a pulse does not affect that pulse. It is staged for the next pulse.
- R10: `live_sec_o` changes only on a pulse.
- R11: A snapshot request copies `live_sec_o` and `live_sub_o` as they stand in that cycle into `snap_sec_o` and `snap_sub_o`. The snapshot outputs hold their value when no request is made.
- R12: Staging wraps modulo 2^32. The value 0xFFFFFFFF stages 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pps_i | input | 1 | One-second pulse, one cycle wide |
| upd_valid_i | input | 1 | Time message strobe |
| upd_sec_i | input | 32 | Seconds value carried by the message |
| snap_req_i | input | 1 | Snapshot capture request |
| tick_irq_o | output | 1 | Tick interrupt strobe, one cycle wide |
| live_sec_o | output | 32 | Live whole seconds |
| live_sub_o | output | 16 | Live sub-second field |
| snap_sec_o | output | 32 | Snapshot of whole seconds |
| snap_sub_o | output | 16 | Snapshot of the sub-second field |

## Verification
A fault in the divider appears as a tick that arrives one or more cycles away from where `REF_DIV` places it, counted from the last pulse. This shows up at the first tick after the fault. A stale or wrongly cleared staged-data flag shows up as a wrong seconds value on the first pulse after the fault. The tick count and the snapshot register show any error on the very next cycle. For this reason, every cycle of a small-divider build is compared against arithmetic expectations, across sweeps of pulse spacing and message timing.

// File: rtl/mtu_pkg.sv
// Shared definitions for the mission time unit.
// Assumes: consumers import this package before declaring their ports.
package mtu_pkg;
    localparam int unsigned DEF_SEC_W   = 32;
    localparam int unsigned DEF_SUB_W   = 16;
    localparam int unsigned DEF_REF_DIV = 32768;
    localparam int unsigned DEF_TICKS   = 256;

    // Action taken on the seconds register in one cycle.
    typedef enum logic [1:0] {
        SEC_HOLD = 2'd0,
        SEC_LOAD = 2'd1,
        SEC_STEP = 2'd2
    } sec_action_e;
endpackage

// File: rtl/mtu_tick_div.sv
// Reference-clock divider that produces the sub-second tick.
// Purpose: output a one-cycle tick every REF_DIV cycles, with the phase
// restarted by the one-second pulse.
// Assumes: REF_DIV >= 2, and pps_i is one cycle wide.
module mtu_tick_div #(
    parameter int unsigned REF_DIV = mtu_pkg::DEF_REF_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Tick on the last count. The pulse takes priority and suppresses it.
    assign tick_o = (cnt_q == LAST) && !pps_i;

    // Cycle counter: restarted by the pulse, wraps after LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (pps_i || cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: a tick never lasts more than one cycle
    a_r2_tick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    // R3: the pulse restarts the phase
    a_r3_pps_restart: assert property (@(posedge clk) disable iff (!rst_n)
        pps_i |=> (cnt_q == '0));
    // R3: no tick in a pulse cycle
    a_r3_no_tick_on_pps: assert property (@(posedge clk) disable iff (!rst_n)
        pps_i |-> !tick_o);
endmodule

// File: rtl/mtu_stage.sv
// Next-second staging register.
// Purpose: hold (message seconds + 1) until the next one-second pulse.
// Assumes: a message in a pulse cycle is meant for the following pulse.
module mtu_stage #(
    parameter int unsigned SEC_W = mtu_pkg::DEF_SEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid_i,
    input  logic [SEC_W-1:0] upd_sec_i,
    input  logic             pps_i,
    output logic [SEC_W-1:0] stage_sec_o,
    output logic             stage_vld_o
);
    // Stage value: the message seconds plus one, modulo 2^SEC_W.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_sec_o <= '0;
        else if (upd_valid_i)
            stage_sec_o <= upd_sec_i + 1'b1;
    end

    // Valid flag: set by a message, used up by a pulse with no message.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_vld_o <= 1'b0;
        else if (upd_valid_i)
            stage_vld_o <= 1'b1;
        else if (pps_i)
            stage_vld_o <= 1'b0;
    end

    // R6: a message always leaves data staged
    a_r6_msg_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_i |=> stage_vld_o);
    // R8: a pulse with no message uses up the staged data
    a_r8_pps_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (pps_i && !upd_valid_i) |=> !stage_vld_o);
endmodule

// File: rtl/mtu_live.sv
// Live time register: whole seconds and the sub-second tick count.
// Purpose: commit the staged seconds (or step by one) on each pulse, and
// count ticks between pulses in the upper bits of the sub-second field.
// Assumes: TICK_W <= SUB_W, and tick_i is never high in a pulse cycle.
module mtu_live
    import mtu_pkg::*;
#(
    parameter int unsigned SEC_W  = DEF_SEC_W,
    parameter int unsigned SUB_W  = DEF_SUB_W,
    parameter int unsigned TICK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps_i,
    input  logic             tick_i,
    input  logic [SEC_W-1:0] stage_sec_i,
    input  logic             stage_vld_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [SUB_W-1:0] sub_o
);
    logic [TICK_W-1:0] tick_cnt_q;
    sec_action_e       sec_act;

    // Decide this cycle's action on the seconds register.
    always_comb begin
        if (!pps_i)
            sec_act = SEC_HOLD;
        else if (stage_vld_i)
            sec_act = SEC_LOAD;
        else
            sec_act = SEC_STEP;
    end

    // Seconds register: load the staged value or step by one on a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sec_o <= '0;
        else begin
            case (sec_act)
                SEC_LOAD: sec_o <= stage_sec_i;
                SEC_STEP: sec_o <= sec_o + 1'b1;
                default:  sec_o <= sec_o;
            endcase
        end
    end

    // Tick count: cleared by a pulse, advanced by each tick, wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n || pps_i)
            tick_cnt_q <= '0;
        else if (tick_i)
            tick_cnt_q <= tick_cnt_q + 1'b1;
    end

    // Place the tick count in the upper bits of the sub-second field.
    generate
        if (SUB_W > TICK_W) begin : g_pad
            assign sub_o = {tick_cnt_q, {(SUB_W - TICK_W){1'b0}}};
        end else begin : g_full
            assign sub_o = tick_cnt_q;
        end
    endgenerate

    // R10: seconds move only on a pulse
    a_r10_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pps_i |=> $stable(sec_o));
    // R7: a pulse with nothing staged steps the seconds by one
    a_r7_pps_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (pps_i && !stage_vld_i) |=> (sec_o == $past(sec_o) + 1'b1));
    // R5: a pulse clears the sub-second field
    a_r5_pps_clears_sub: assert property (@(posedge clk) disable iff (!rst_n)
        pps_i |=> (sub_o == '0));
    // R4: each tick adds one to the count
    a_r4_tick_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !pps_i) |=> (tick_cnt_q == $past(tick_cnt_q) + 1'b1));
endmodule

// File: rtl/mtu_snap.sv
// Snapshot holding register for packet time stamps.
// Purpose: capture all seconds and sub-second bits in one cycle on request.
// Assumes: the inputs are register outputs, so they are stable within a cycle.
module mtu_snap #(
    parameter int unsigned SEC_W = mtu_pkg::DEF_SEC_W,
    parameter int unsigned SUB_W = mtu_pkg::DEF_SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [SUB_W-1:0] sub_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [SUB_W-1:0] sub_o
);
    // Holding register: loaded whole on request, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_o <= '0;
            sub_o <= '0;
        end else if (req_i) begin
            sec_o <= sec_i;
            sub_o <= sub_i;
        end
    end

    // R11: without a request the snapshot holds
    a_r11_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(sec_o) && $stable(sub_o)));
    // R11: a request captures the values from the request cycle
    a_r11_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (sec_o == $past(sec_i) && sub_o == $past(sub_i)));
endmodule

// File: rtl/mission_time_unit.sv
// Top of the mission time unit.
// Purpose: divide the reference clock into ticks, stage incoming time
// messages, commit them on the one-second pulse, and offer a snapshot.
// Assumes: pps_i is synchronous and one cycle wide; TICKS_PER_SEC is a
// power of two no wider than the sub-second field.
module mission_time_unit
    import mtu_pkg::*;
#(
    parameter int unsigned SEC_W         = DEF_SEC_W,
    parameter int unsigned SUB_W         = DEF_SUB_W,
    parameter int unsigned REF_DIV       = DEF_REF_DIV,
    parameter int unsigned TICKS_PER_SEC = DEF_TICKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps_i,
    input  logic             upd_valid_i,
    input  logic [SEC_W-1:0] upd_sec_i,
    input  logic             snap_req_i,
    output logic             tick_irq_o,
    output logic [SEC_W-1:0] live_sec_o,
    output logic [SUB_W-1:0] live_sub_o,
    output logic [SEC_W-1:0] snap_sec_o,
    output logic [SUB_W-1:0] snap_sub_o
);
    localparam int unsigned TICK_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

    logic             tick;
    logic [SEC_W-1:0] stage_sec;
    logic             stage_vld;

    mtu_tick_div #(.REF_DIV(REF_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .pps_i  (pps_i),
        .tick_o (tick)
    );

    mtu_stage #(.SEC_W(SEC_W)) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_valid_i (upd_valid_i),
        .upd_sec_i   (upd_sec_i),
        .pps_i       (pps_i),
        .stage_sec_o (stage_sec),
        .stage_vld_o (stage_vld)
    );

    mtu_live #(.SEC_W(SEC_W), .SUB_W(SUB_W), .TICK_W(TICK_W)) u_live (
        .clk         (clk),
        .rst_n       (rst_n),
        .pps_i       (pps_i),
        .tick_i      (tick),
        .stage_sec_i (stage_sec),
        .stage_vld_i (stage_vld),
        .sec_o       (live_sec_o),
        .sub_o       (live_sub_o)
    );

    mtu_snap #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (snap_req_i),
        .sec_i (live_sec_o),
        .sub_i (live_sub_o),
        .sec_o (snap_sec_o),
        .sub_o (snap_sub_o)
    );

    assign tick_irq_o = tick;

    // R9: a message in a pulse cycle does not change what that pulse commits
    a_r9_same_cycle_msg: assert property (@(posedge clk) disable iff (!rst_n)
        (pps_i && upd_valid_i && !stage_vld) |=> (live_sec_o == $past(live_sec_o) + 1'b1));
    // R1: the reset state is seen on the first edge after reset is released
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (live_sec_o == '0 && live_sub_o == '0 && snap_sec_o == '0));
endmodule

// File: tb/test_mission_time_unit.sv
module test_mission_time_unit;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pps = 1'b0, upd = 1'b0, snap = 1'b0;
    logic [31:0] upd_sec = '0;
    logic        tick_irq;
    logic [31:0] live_sec, snap_sec;
    logic [15:0] live_sub, snap_sub;

    int n_tests = 0;
    int n_fail  = 0;

    // arithmetic expectation state
    int          m_cnt = 0;
    logic [7:0]  m_tick = '0;
    logic [31:0] m_sec = '0, m_stage = '0, m_snap_sec = '0;
    logic [15:0] m_snap_sub = '0;
    logic        m_valid = 1'b0;

    always #2.5 clk = ~clk;

    mission_time_unit #(.REF_DIV(DIV)) i_mission_time_unit (
        .clk(clk), .rst_n(rst_n), .pps_i(pps), .upd_valid_i(upd),
        .upd_sec_i(upd_sec), .snap_req_i(snap), .tick_irq_o(tick_irq),
        .live_sec_o(live_sec), .live_sub_o(live_sub),
        .snap_sec_o(snap_sec), .snap_sub_o(snap_sub)
    );

    function automatic logic exp_tick();
        return (m_cnt == DIV - 1) && !pps;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_tick <= '0; m_sec <= '0; m_stage <= '0;
            m_valid <= 1'b0; m_snap_sec <= '0; m_snap_sub <= '0;
        end else begin
            m_cnt <= (pps || m_cnt == DIV - 1) ? 0 : m_cnt + 1;
            if (pps) begin
                m_sec  <= m_valid ? m_stage : m_sec + 32'd1;
                m_tick <= '0;
            end else if (exp_tick())
                m_tick <= m_tick + 8'd1;
            if (upd) begin
                m_stage <= upd_sec + 32'd1;
                m_valid <= 1'b1;
            end else if (pps)
                m_valid <= 1'b0;
            if (snap) begin
                m_snap_sec <= m_sec;
                m_snap_sub <= {m_tick, 8'h00};
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R2 tick strobe", 64'(tick_irq), 64'(exp_tick()));
        chk("R4 sub-second field", 64'(live_sub), 64'({m_tick, 8'h00}));
        chk("R7 live seconds", 64'(live_sec), 64'(m_sec));
        chk("R11 snapshot", {snap_sec, snap_sub, 16'h0}, {m_snap_sec, m_snap_sub, 16'h0});
    endtask

    // one cycle: drive inputs after the falling edge, check, wait for next fall
    task automatic cyc(input logic p, input logic u, input logic [31:0] v, input logic s);
        pps = p; upd = u; upd_sec = v; snap = s;
        #1;
        check_all();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 32'h0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 live seconds", 64'(live_sec), 64'h0);
        chk("R1 sub-second", 64'(live_sub), 64'h0);
        chk("R1 snapshot", 64'(snap_sec), 64'h0);
        chk("R1 tick", 64'(tick_irq), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        idle(3 * DIV + 2);

        // R3: first tick DIV cycles after the pulse cycle
        cyc(1'b1, 1'b0, 32'h0, 1'b0);
        for (int k = 1; k <= DIV; k++) begin
            pps = 1'b0; upd = 1'b0; snap = 1'b0;
            #1;
            chk("R3 tick phase after pulse", 64'(tick_irq), 64'(k == DIV));
            check_all();
            @(negedge clk);
        end

        // R6 / R8: staged value loads once, then stepping resumes
        idle(5);
        cyc(1'b0, 1'b1, 32'd100, 1'b0);
        idle(3);
        cyc(1'b1, 1'b0, 32'h0, 1'b0);
        #1; chk("R6 staged load", 64'(live_sec), 64'd101);
        chk("R5 sub cleared", 64'(live_sub), 64'h0);
        idle(20);
        cyc(1'b1, 1'b0, 32'h0, 1'b0);
        #1; chk("R8 step after use", 64'(live_sec), 64'd102);

        // R9: a message in the pulse cycle waits for the next pulse
        cyc(1'b0, 1'b1, 32'd200, 1'b0);
        idle(4);
        cyc(1'b1, 1'b1, 32'd500, 1'b0);
        #1; chk("R9 pulse uses earlier stage", 64'(live_sec), 64'd201);
        idle(6);
        cyc(1'b1, 1'b0, 32'h0, 1'b0);
        #1; chk("R9 later pulse uses new stage", 64'(live_sec), 64'd501);

        // R12: staging wraps
        cyc(1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0);
        cyc(1'b1, 1'b0, 32'h0, 1'b0);
        #1; chk("R12 wrap to zero", 64'(live_sec), 64'h0);

        // R10 / R4: a long run without pulses wraps the count, seconds hold
        idle(257 * DIV + 3);
        #1; chk("R10 seconds held", 64'(live_sec), 64'h0);
        chk("R4 count wrapped", 64'(live_sub), 64'({8'(257 % 256), 8'h00}));

        // R11 and sweep: pulse spacing, message timing, snapshots
        for (int sp = 1; sp <= 3 * DIV + 3; sp++) begin
            for (int rep = 0; rep < 3; rep++) begin
                for (int c = 0; c < sp; c++) begin
                    cyc(c == sp - 1,
                        (rep != 1) && (c == (sp / 2)),
                        32'(sp * 1000 + rep * 17 + c),
                        ((c + rep) % 3) == 0);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule